// File: doc/BRIEF.md
# Configuration Byte Readback Window

This block sits next to the program-memory load path of a small processor. Software can use it to fetch the non-volatile configuration bytes, meaning the lock bits and three fuse bytes, with the ordinary program-memory load instruction. The processor's register decode delivers two arm bits: a lock-set bit and a self-program-enable bit. When software writes both of them high, a short window opens. A load issued inside that window does not return program-memory data. It returns the configuration byte selected by the two low bits of the address pointer.

The block drives two things: the select for the load data multiplexer and the byte to return. The arm bits clear themselves in three cases: after a redirected read, after a store-to-program-memory, or when their windows run out. While a data-EEPROM write is in progress, writes to the arm bits are ignored and loads are not redirected.

Top module: `cfg_readback`

## Requirements
- R1: With `ee_busy` low, a pulse on `ctl_wr_en` loads `ctl_wr_arm` into the arm bits. `arm_bits` shows the new value from the next cycle. Bit 1 is lock-set and bit 0 is self-program-enable.
- R2: `cfg_sel` is high in the same cycle as `ld_req` only if all of these hold: both arm bits are high, `ee_busy` is low, and the load falls in one of the first three cycles after the arm write.
- R3: While `cfg_sel` is high, `ld_ptr_lo` selects the byte: 0 gives the fuse low byte, 1 the lock byte, 2 the extended fuse byte, 3 the fuse high byte.
- R4: A bit whose `*_prog` input is 1 (programmed) reads as 0. A bit whose input is 0 reads as 1. The lock byte carries the two lock bits in bits 1:0 and reads 1 in bits 7:2.
- R5: A redirected load clears both arm bits on the next cycle.
- R6: If both arm bits are set and no load comes in the three cycles after the write, both bits are clear in the fourth cycle.
- R7: If any arm bit is set, both clear after four cycles with no store. A `st_req` with `ee_busy` low clears them on the next cycle.
- R8: While `ee_busy` is high, an arm write has no effect. A load is also neither redirected nor counted as the completing read.
- R9: Whenever `cfg_sel` is low, `cfg_data` is 0. This covers every load made with the arm bits clear.
- R10: An accepted arm write restarts both windows. If it falls in the same cycle as a redirected load, the write decides the next arm state.
- R11: A synchronous `rst` clears the arm bits and both window counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_wr_en | input | 1 | Arm-bit write strobe |
| ctl_wr_arm | input | 2 | Arm-bit write value {lock-set, self-program-enable} |
| ld_req | input | 1 | Program-memory load issued this cycle |
| st_req | input | 1 | Store-to-program-memory issued this cycle |
| ld_ptr_lo | input | 2 | Low two bits of the load address pointer |
| ee_busy | input | 1 | Data-EEPROM write in progress |
| fuse_lo_prog | input | 8 | Fuse low byte, 1 = programmed |
| fuse_hi_prog | input | 8 | Fuse high byte, 1 = programmed |
| fuse_ext_prog | input | 8 | Extended fuse byte, 1 = programmed |
| lock_prog | input | 2 | Lock bits, 1 = programmed |
| cfg_sel | output | 1 | Load data multiplexer takes `cfg_data` |
| cfg_data | output | 8 | Configuration byte to return |
| arm_bits | output | 2 | Current arm bits {lock-set, self-program-enable} |

## Verification
Two functions can coincide in one cycle: an arm write and a redirected load. The bench provokes this by pulsing the write in the first window cycle together with the load. It judges the outcome two ways: the load must still be redirected using the old state, and the arm bits must then show the written value, not a cleared state. A second collision pairs `ee_busy` with an armed load. There the bench expects program-memory data, and expects the window to survive into the following cycle, where an unblocked load is redirected.

// File: rtl/cfg_readback_pkg.sv
package cfg_readback_pkg;

    typedef enum logic [1:0] {
        SEL_FUSE_LO  = 2'd0,
        SEL_LOCK     = 2'd1,
        SEL_FUSE_EXT = 2'd2,
        SEL_FUSE_HI  = 2'd3
    } cfg_pick_e;

    localparam int CFG_BYTE_W = 8;
    localparam int LOCK_W     = 2;

endpackage

// File: rtl/cfg_readback_window.sv
module cfg_readback_window #(
    parameter int LD_WIN = 3,
    parameter int ST_WIN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_arm,
    input  logic       ld_req,
    input  logic       st_req,
    input  logic       ee_busy,
    output logic       redirect,
    output logic [1:0] arm
);
    localparam int LD_CW = $clog2(LD_WIN + 1);
    localparam int ST_CW = $clog2(ST_WIN + 1);

    typedef struct packed {
        logic             lock_set;
        logic             spe;
        logic [LD_CW-1:0] ld_left;
        logic [ST_CW-1:0] st_left;
    } win_state_t;

    win_state_t st_d, st_q;
    logic wr_ok, both, any, ld_expire, st_expire, st_take;

    always_comb begin
        st_d      = st_q;
        wr_ok     = wr_en && !ee_busy;
        both      = st_q.lock_set && st_q.spe;
        any       = st_q.lock_set || st_q.spe;
        redirect  = ld_req && both && !ee_busy && (st_q.ld_left != '0);
        ld_expire = both && (st_q.ld_left == LD_CW'(1));
        st_expire = any && (st_q.st_left == ST_CW'(1));
        st_take   = any && st_req && !ee_busy;

        if (any) begin
            if (st_q.ld_left != '0) st_d.ld_left = st_q.ld_left - LD_CW'(1);
            if (st_q.st_left != '0) st_d.st_left = st_q.st_left - ST_CW'(1);
        end

        if (redirect || ld_expire || st_expire || st_take) begin
            st_d.lock_set = 1'b0;
            st_d.spe      = 1'b0;
            st_d.ld_left  = '0;
            st_d.st_left  = '0;
        end

        if (wr_ok) begin
            st_d.lock_set = wr_arm[1];
            st_d.spe      = wr_arm[0];
            st_d.ld_left  = LD_CW'(LD_WIN);
            st_d.st_left  = ST_CW'(ST_WIN);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign arm = {st_q.lock_set, st_q.spe};

endmodule

// File: rtl/cfg_readback_mux.sv
module cfg_readback_mux
    import cfg_readback_pkg::*;
(
    input  logic [1:0]            pick,
    input  logic [CFG_BYTE_W-1:0] fuse_lo_prog,
    input  logic [CFG_BYTE_W-1:0] fuse_hi_prog,
    input  logic [CFG_BYTE_W-1:0] fuse_ext_prog,
    input  logic [LOCK_W-1:0]     lock_prog,
    output logic [CFG_BYTE_W-1:0] byte_out
);
    logic [CFG_BYTE_W-1:0] prog_sel;

    always_comb begin
        unique case (cfg_pick_e'(pick))
            SEL_FUSE_LO:  prog_sel = fuse_lo_prog;
            SEL_LOCK:     prog_sel = {{(CFG_BYTE_W-LOCK_W){1'b0}}, lock_prog};
            SEL_FUSE_EXT: prog_sel = fuse_ext_prog;
            SEL_FUSE_HI:  prog_sel = fuse_hi_prog;
            default:      prog_sel = '0;
        endcase
        byte_out = ~prog_sel;
    end

endmodule

// File: rtl/cfg_readback.sv
module cfg_readback
    import cfg_readback_pkg::*;
#(
    parameter int LD_WIN = 3,
    parameter int ST_WIN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_wr_en,
    input  logic [1:0] ctl_wr_arm,
    input  logic       ld_req,
    input  logic       st_req,
    input  logic [1:0] ld_ptr_lo,
    input  logic       ee_busy,
    input  logic [7:0] fuse_lo_prog,
    input  logic [7:0] fuse_hi_prog,
    input  logic [7:0] fuse_ext_prog,
    input  logic [1:0] lock_prog,
    output logic       cfg_sel,
    output logic [7:0] cfg_data,
    output logic [1:0] arm_bits
);
    logic [CFG_BYTE_W-1:0] picked;
    logic                  redirect;

    cfg_readback_window #(
        .LD_WIN (LD_WIN),
        .ST_WIN (ST_WIN)
    ) u_window (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (ctl_wr_en),
        .wr_arm   (ctl_wr_arm),
        .ld_req   (ld_req),
        .st_req   (st_req),
        .ee_busy  (ee_busy),
        .redirect (redirect),
        .arm      (arm_bits)
    );

    cfg_readback_mux u_mux (
        .pick          (ld_ptr_lo),
        .fuse_lo_prog  (fuse_lo_prog),
        .fuse_hi_prog  (fuse_hi_prog),
        .fuse_ext_prog (fuse_ext_prog),
        .lock_prog     (lock_prog),
        .byte_out      (picked)
    );

    assign cfg_sel  = redirect;
    assign cfg_data = redirect ? picked : '0;

endmodule

// File: rtl/cfg_readback_chk.sv
module cfg_readback_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctl_wr_en,
    input logic       ee_busy,
    input logic       ld_req,
    input logic       cfg_sel,
    input logic [7:0] cfg_data,
    input logic [1:0] arm_bits
);
    logic [2:0] age_q;

    always_ff @(posedge clk) begin
        if (rst)                         age_q <= '0;
        else if (ctl_wr_en && !ee_busy)  age_q <= '0;
        else if (arm_bits != 2'b00 && age_q != 3'd7) age_q <= age_q + 3'd1;
    end

    // R2
    redirect_window_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_sel |-> (arm_bits == 2'b11 && ld_req && !ee_busy && age_q < 3'd3));

    // R5
    consume_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_sel && !(ctl_wr_en && !ee_busy)) |=> (arm_bits == 2'b00));

    // R6
    load_expire_chk: assert property (@(posedge clk) disable iff (rst)
        (arm_bits == 2'b11) |-> (age_q < 3'd3));

    // R7
    store_expire_chk: assert property (@(posedge clk) disable iff (rst)
        (arm_bits != 2'b00) |-> (age_q < 3'd4));

    // R8
    busy_write_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr_en && ee_busy && arm_bits == 2'b00) |=> (arm_bits == 2'b00));

    // R9
    idle_data_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_sel |-> (cfg_data == 8'h00));

endmodule

bind cfg_readback cfg_readback_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctl_wr_en (ctl_wr_en),
    .ee_busy   (ee_busy),
    .ld_req    (ld_req),
    .cfg_sel   (cfg_sel),
    .cfg_data  (cfg_data),
    .arm_bits  (arm_bits)
);

// File: tb/cfg_readback_bench.sv
module cfg_readback_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       ctl_wr_en;
    logic [1:0] ctl_wr_arm;
    logic       ld_req, st_req, ee_busy;
    logic [1:0] ld_ptr_lo;
    logic [7:0] fuse_lo_prog, fuse_hi_prog, fuse_ext_prog;
    logic [1:0] lock_prog;
    logic       cfg_sel;
    logic [7:0] cfg_data;
    logic [1:0] arm_bits;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cfg_readback u_cfg_readback (
        .clk(clk), .rst(rst), .ctl_wr_en(ctl_wr_en), .ctl_wr_arm(ctl_wr_arm),
        .ld_req(ld_req), .st_req(st_req), .ld_ptr_lo(ld_ptr_lo), .ee_busy(ee_busy),
        .fuse_lo_prog(fuse_lo_prog), .fuse_hi_prog(fuse_hi_prog),
        .fuse_ext_prog(fuse_ext_prog), .lock_prog(lock_prog),
        .cfg_sel(cfg_sel), .cfg_data(cfg_data), .arm_bits(arm_bits)
    );

    // {fuse_lo, fuse_hi, fuse_ext, lock, ptr, expected byte}
    localparam int NV = 10;
    localparam logic [35:0] VEC [NV] = '{
        {8'hA5, 8'h3C, 8'h0F, 2'b01, 2'd0, 8'h5A},
        {8'hA5, 8'h3C, 8'h0F, 2'b01, 2'd1, 8'hFE},
        {8'hA5, 8'h3C, 8'h0F, 2'b01, 2'd2, 8'hF0},
        {8'hA5, 8'h3C, 8'h0F, 2'b01, 2'd3, 8'hC3},
        {8'h00, 8'hFF, 8'h81, 2'b00, 2'd0, 8'hFF},
        {8'h00, 8'hFF, 8'h81, 2'b00, 2'd1, 8'hFF},
        {8'h00, 8'hFF, 8'h81, 2'b00, 2'd2, 8'h7E},
        {8'h00, 8'hFF, 8'h81, 2'b00, 2'd3, 8'h00},
        {8'h12, 8'h34, 8'h56, 2'b11, 2'd1, 8'hFC},
        {8'h12, 8'h34, 8'h56, 2'b10, 2'd3, 8'hCB}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic arm_write(input logic [1:0] v);
        ctl_wr_en  = 1'b1;
        ctl_wr_arm = v;
        cyc();
        ctl_wr_en  = 1'b0;
    endtask

    initial begin
        rst = 1'b1; ctl_wr_en = 0; ctl_wr_arm = 0; ld_req = 0; st_req = 0;
        ee_busy = 0; ld_ptr_lo = 0;
        fuse_lo_prog = 0; fuse_hi_prog = 0; fuse_ext_prog = 0; lock_prog = 0;
        @(negedge clk); cyc();
        rst = 1'b0;
        #1;
        chk("R11 reset arm", {6'b0, arm_bits}, 8'h00);
        chk("R9 reset sel", {7'b0, cfg_sel}, 8'h00);

        // R9: unarmed load is a normal read
        ld_req = 1; ld_ptr_lo = 2'd1; #1;
        chk("R9 unarmed sel", {7'b0, cfg_sel}, 8'h00);
        chk("R9 unarmed data", cfg_data, 8'h00);
        cyc(); ld_req = 0;

        // table walk: R1 R2 R3 R4 R5, load placed in window cycle 1..3
        for (int i = 0; i < NV; i++) begin
            {fuse_lo_prog, fuse_hi_prog, fuse_ext_prog, lock_prog} = VEC[i][35:10];
            arm_write(2'b11);
            chk("R1 armed", {6'b0, arm_bits}, 8'h03);
            for (int w = 0; w < i % 3; w++) cyc();
            ld_req = 1; ld_ptr_lo = VEC[i][9:8]; #1;
            chk("R2 redirect", {7'b0, cfg_sel}, 8'h01);
            chk("R3 R4 byte", cfg_data, VEC[i][7:0]);
            cyc(); ld_req = 0; #1;
            chk("R5 consumed", {6'b0, arm_bits}, 8'h00);
            cyc();
        end

        // R6: both armed, no load -> cleared in fourth cycle; late load not redirected
        arm_write(2'b11);
        cyc(); cyc();
        chk("R6 third cycle", {6'b0, arm_bits}, 8'h03);
        cyc();
        chk("R6 expired", {6'b0, arm_bits}, 8'h00);
        ld_req = 1; ld_ptr_lo = 0; #1;
        chk("R2 late load", {7'b0, cfg_sel}, 8'h00);
        cyc(); ld_req = 0;

        // R7: single arm bit lasts four cycles
        arm_write(2'b01);
        cyc(); cyc(); cyc();
        chk("R7 fourth cycle", {6'b0, arm_bits}, 8'h01);
        ld_req = 1; #1;
        chk("R2 single bit no redirect", {7'b0, cfg_sel}, 8'h00);
        cyc(); ld_req = 0;
        chk("R7 expired", {6'b0, arm_bits}, 8'h00);

        // R7: store consumes arm bits
        arm_write(2'b11);
        st_req = 1; cyc(); st_req = 0;
        chk("R7 store clears", {6'b0, arm_bits}, 8'h00);

        // R8: busy write ignored
        ee_busy = 1; arm_write(2'b11); ee_busy = 0;
        chk("R8 busy write", {6'b0, arm_bits}, 8'h00);

        // R8: busy load not redirected and not consumed
        fuse_lo_prog = 8'h0F;
        arm_write(2'b11);
        ee_busy = 1; ld_req = 1; ld_ptr_lo = 0; #1;
        chk("R8 busy load sel", {7'b0, cfg_sel}, 8'h00);
        chk("R8 busy load data", cfg_data, 8'h00);
        cyc(); ee_busy = 0; #1;
        chk("R8 window kept", {6'b0, arm_bits}, 8'h03);
        chk("R8 later redirect", {7'b0, cfg_sel}, 8'h01);
        chk("R3 fuse low", cfg_data, 8'hF0);
        cyc(); ld_req = 0;

        // R10: rewrite restarts windows
        arm_write(2'b11);
        cyc(); cyc();
        arm_write(2'b11);
        cyc(); cyc();
        chk("R10 restarted", {6'b0, arm_bits}, 8'h03);
        cyc();
        chk("R10 expires after restart", {6'b0, arm_bits}, 8'h00);

        // R10: write and redirected load in the same cycle
        arm_write(2'b11);
        ld_req = 1; ctl_wr_en = 1; ctl_wr_arm = 2'b11; #1;
        chk("R10 same-cycle redirect", {7'b0, cfg_sel}, 8'h01);
        cyc(); ld_req = 0; ctl_wr_en = 0; #1;
        chk("R10 write wins", {6'b0, arm_bits}, 8'h03);

        // R11: reset while armed
        rst = 1; cyc(); rst = 0; #1;
        chk("R11 reset clears", {6'b0, arm_bits}, 8'h00);
        cyc();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule